// File: doc/BRIEF.md
# Auto-Reload Down-Counting Interval Timer

This block is a down-counting interval timer with no waveform output. Software programs a count buffer through a small register port, then pulses a manual-update control to copy the buffer into the working counter. With the run control set, the counter steps down by one on every cycle in which the tick enable input is high. When a tick arrives while the counter already stands at zero, the counter expires and a one-cycle interrupt pulse is raised.

On expiry, the auto-reload control picks what happens next. If it is set, the counter takes the buffer value again and keeps counting, which gives a periodic interrupt. If it is clear, the counter stays at zero and stays quiet until the next manual update. The buffer can be rewritten while the counter runs. The new value is only used at the next reload. A read-only observation register returns the live count at any time.

Top module: `reload_timer`

## Requirements
- R1: After reset the control bits, the buffer, the counter and the interrupt output are all 0, and every register reads back 0.
- R2: Register map on `reg_addr`: 0 is control (bit 0 run, bit 1 manual update, bit 2 auto-reload, other bits read 0), 1 is the count buffer, 2 is the read-only live count, and 3 reads 0. Writes to 2 and 3 have no effect. `reg_rdata` shows the addressed register in the same cycle, and a write becomes visible after the clock edge that takes it.
- R3: While the manual-update bit is 1, the counter takes the buffer value at every clock edge, whatever the run bit and the tick input are. It also clears the stopped state described in R6.
- R4: With run 1 and manual update 0, a tick while the count is nonzero lowers the count by exactly one. The count never changes on a cycle without a tick.
- R5: A tick at count 0, with run 1, manual update 0 and the counter not stopped, is an expiry. With auto-reload 1, the counter takes the buffer value at that edge, so a buffer of N gives N, N-1, ..., 0, N, ...
- R6: On an expiry with auto-reload 0, the counter stays at 0 and becomes stopped. Later ticks cause no further expiry until a manual update.
- R7: Each expiry gives `irq_pulse` high for exactly the one cycle after the expiry edge. At all other times `irq_pulse` is low.
- R8: Writing the buffer while the counter runs leaves the present count untouched. The new value is used at the next reload.
- R9: With run 0 (and manual update 0), the counter holds its value through ticks, and the buffer is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | CNT_W (16) | Write data |
| reg_rdata | output | CNT_W (16) | Read data of the addressed register |
| tick_en | input | 1 | Timer tick, one count step per high cycle |
| irq_pulse | output | 1 | One-cycle expiry interrupt |

## Verification
The assertions assume a few things about the inputs: `tick_en`, `reg_wr` and the write data are stable across each clock edge, and software holds the manual-update bit only as long as it wants the counter forced to the buffer. Under those assumptions, every counter change comes from exactly one of these events: a load, a decrement or an expiry. The stimulus drives all inputs on the falling edge and changes the control register only through whole-cycle writes. Each manual update is one write with the bit set, followed by a write that clears it.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

  localparam int REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_BUFFER = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_COUNT  = 2'd2;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_LOAD_BIT = 1;
  localparam int CTRL_AUTO_BIT = 2;
  localparam int CTRL_BITS     = 3;

  typedef struct packed {
    logic autorl;
    logic load;
    logic run;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_bits(input logic [CTRL_BITS-1:0] b);
    ctrl_t c;
    c.run    = b[CTRL_RUN_BIT];
    c.load   = b[CTRL_LOAD_BIT];
    c.autorl = b[CTRL_AUTO_BIT];
    return c;
  endfunction

  function automatic logic [CTRL_BITS-1:0] ctrl_to_bits(input ctrl_t c);
    logic [CTRL_BITS-1:0] b;
    b = '0;
    b[CTRL_RUN_BIT]  = c.run;
    b[CTRL_LOAD_BIT] = c.load;
    b[CTRL_AUTO_BIT] = c.autorl;
    return b;
  endfunction

endpackage

// File: rtl/reload_timer_regs.sv
module reload_timer_regs
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]      wdata_i,
  input  logic [CNT_W-1:0]      count_i,
  output ctrl_t                 ctrl_o,
  output logic [CNT_W-1:0]      buf_o,
  output logic [CNT_W-1:0]      rdata_o
);

  localparam int PAD_W = CNT_W - CTRL_BITS;

  logic ctrl_we;
  logic buf_we;

  assign ctrl_we = wr_i && (addr_i == ADDR_CTRL);
  assign buf_we  = wr_i && (addr_i == ADDR_BUFFER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_o <= '0;
      buf_o  <= '0;
    end else begin
      if (ctrl_we) ctrl_o <= ctrl_from_bits(wdata_i[CTRL_BITS-1:0]);
      if (buf_we)  buf_o  <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL:   rdata_o = {{PAD_W{1'b0}}, ctrl_to_bits(ctrl_o)};
      ADDR_BUFFER: rdata_o = buf_o;
      ADDR_COUNT:  rdata_o = count_i;
      default:     rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/reload_timer_core.sv
module reload_timer_core
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl_i,
  input  logic [CNT_W-1:0] buf_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             load_evt_o,
  output logic             dec_evt_o,
  output logic             expire_evt_o,
  output logic             halted_o
);

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] after_expiry(input logic autorl,
                                                    input logic [CNT_W-1:0] b);
    return autorl ? b : '0;
  endfunction

  logic             step;
  logic             at_zero;
  logic [CNT_W-1:0] count_d;
  logic             halted_d;

  assign at_zero      = (count_o == '0);
  assign load_evt_o   = ctrl_i.load;
  assign step         = ctrl_i.run && tick_i && !ctrl_i.load;
  assign dec_evt_o    = step && !at_zero;
  assign expire_evt_o = step && at_zero && !halted_o;

  always_comb begin
    count_d  = count_o;
    halted_d = halted_o;
    if (load_evt_o) begin
      count_d  = buf_i;
      halted_d = 1'b0;
    end else if (dec_evt_o) begin
      count_d  = step_down(count_o);
    end else if (expire_evt_o) begin
      count_d  = after_expiry(ctrl_i.autorl, buf_i);
      halted_d = !ctrl_i.autorl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o  <= '0;
      halted_o <= 1'b0;
    end else begin
      count_o  <= count_d;
      halted_o <= halted_d;
    end
  end

endmodule

// File: rtl/reload_timer_irq.sv
module reload_timer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  output logic irq_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= expire_i;
  end

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]      reg_wdata,
  output logic [CNT_W-1:0]      reg_rdata,
  input  logic                  tick_en,
  output logic                  irq_pulse
);

  ctrl_t            ctrl_w;
  logic [CNT_W-1:0] buf_w;
  logic [CNT_W-1:0] count_w;
  logic             load_evt;
  logic             dec_evt;
  logic             expire_evt;
  logic             halted_w;

  reload_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .count_i (count_w),
    .ctrl_o  (ctrl_w),
    .buf_o   (buf_w),
    .rdata_o (reg_rdata)
  );

  reload_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_i       (ctrl_w),
    .buf_i        (buf_w),
    .tick_i       (tick_en),
    .count_o      (count_w),
    .load_evt_o   (load_evt),
    .dec_evt_o    (dec_evt),
    .expire_evt_o (expire_evt),
    .halted_o     (halted_w)
  );

  reload_timer_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire_i (expire_evt),
    .irq_o    (irq_pulse)
  );

endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             load,
  input logic             autorl,
  input logic             tick,
  input logic [CNT_W-1:0] buffer,
  input logic [CNT_W-1:0] cnt,
  input logic             load_evt,
  input logic             dec_evt,
  input logic             expire_evt,
  input logic             halted,
  input logic             irq
);

  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(buffer)) && !halted);

  // R4
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_evt |=> cnt == CNT_W'($past(cnt) - CNT_W'(1)));

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt));

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !run) |=> $stable(cnt));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && autorl) |=> cnt == $past(buffer));

  // R6
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !autorl) |=> (cnt == '0) && halted);

  // R6
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !expire_evt);

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> irq);

  // R7
  irq_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !expire_evt |=> !irq);

  // R4
  single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_evt, dec_evt, expire_evt}));

endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (ctrl_w.run),
  .load       (ctrl_w.load),
  .autorl     (ctrl_w.autorl),
  .tick       (tick_en),
  .buffer     (buf_w),
  .cnt        (count_w),
  .load_evt   (load_evt),
  .dec_evt    (dec_evt),
  .expire_evt (expire_evt),
  .halted     (halted_w),
  .irq        (irq_pulse)
);

// File: tb/reload_timer_test.sv
`timescale 1ns/1ps
module reload_timer_test;

  localparam int W = 16;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_BUF  = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;
  localparam logic [1:0] A_NONE = 2'd3;
  localparam logic [W-1:0] C_RUN  = 16'h0001;
  localparam logic [W-1:0] C_LOAD = 16'h0002;
  localparam logic [W-1:0] C_AUTO = 16'h0004;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         tick_en = 1'b0;
  logic         irq_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reload_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en),
    .irq_pulse(irq_pulse)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [W-1:0] exp, input string tag);
    reg_addr = a;
    #0.5;
    check(tag, reg_rdata, exp);
  endtask

  task automatic tick_chk(input logic [W-1:0] exp_cnt, input logic exp_irq, input string tag);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    check({tag, " irq"}, W'(irq_pulse), W'(exp_irq));
    rd(A_CNT, exp_cnt, {tag, " count"});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic manual_load(input logic [W-1:0] value, input logic [W-1:0] next_ctrl);
    wr(A_BUF, value);
    wr(A_CTRL, C_LOAD);
    wr(A_CTRL, next_ctrl);
  endtask

  task automatic t_reset;
    rd(A_CTRL, '0, "R1 ctrl");
    rd(A_BUF, '0, "R1 buffer");
    rd(A_CNT, '0, "R1 count");
    check("R1 irq", W'(irq_pulse), '0);
  endtask

  task automatic t_regmap;
    wr(A_CTRL, 16'hFFF8 | C_AUTO);
    rd(A_CTRL, C_AUTO, "R2 ctrl upper bits read 0");
    wr(A_CTRL, '0);
    wr(A_BUF, 16'hA5C3);
    rd(A_BUF, 16'hA5C3, "R2 buffer readback");
    wr(A_CNT, 16'h1234);
    rd(A_CNT, '0, "R2 count write ignored");
    wr(A_NONE, 16'h00FF);
    rd(A_NONE, '0, "R2 unused address");
  endtask

  task automatic t_load_and_hold;
    manual_load(16'd5, '0);
    rd(A_CNT, 16'd5, "R3 manual update");
    tick_chk(16'd5, 1'b0, "R9 no run, tick ignored");
    rd(A_BUF, 16'd5, "R9 buffer kept");
  endtask

  task automatic t_one_shot;
    wr(A_CTRL, C_RUN);
    idle(3);
    rd(A_CNT, 16'd5, "R4 no tick no change");
    tick_chk(16'd4, 1'b0, "R4 step 4");
    tick_chk(16'd3, 1'b0, "R4 step 3");
    tick_chk(16'd2, 1'b0, "R4 step 2");
    tick_chk(16'd1, 1'b0, "R4 step 1");
    tick_chk(16'd0, 1'b0, "R4 step 0");
    tick_chk(16'd0, 1'b1, "R6 expiry stays 0");
    idle(1);
    check("R7 pulse one cycle", W'(irq_pulse), '0);
    tick_chk(16'd0, 1'b0, "R6 stopped no second irq");
    tick_chk(16'd0, 1'b0, "R6 still stopped");
  endtask

  task automatic t_auto_reload;
    manual_load(16'd3, C_RUN | C_AUTO);
    rd(A_CNT, 16'd3, "R3 load clears stop");
    tick_chk(16'd2, 1'b0, "R5 step 2");
    wr(A_BUF, 16'd7);
    rd(A_CNT, 16'd2, "R8 count undisturbed");
    tick_chk(16'd1, 1'b0, "R8 step 1");
    tick_chk(16'd0, 1'b0, "R8 step 0");
    tick_chk(16'd7, 1'b1, "R8 reload takes new buffer");
    idle(1);
    check("R7 pulse ended", W'(irq_pulse), '0);
    tick_chk(16'd6, 1'b0, "R5 counting continues");
  endtask

  task automatic t_freeze;
    manual_load(16'd9, C_RUN);
    tick_chk(16'd8, 1'b0, "R9 pre step 8");
    tick_chk(16'd7, 1'b0, "R9 pre step 7");
    wr(A_CTRL, '0);
    tick_chk(16'd7, 1'b0, "R9 frozen 1");
    tick_chk(16'd7, 1'b0, "R9 frozen 2");
    rd(A_BUF, 16'd9, "R9 buffer unchanged");
    wr(A_CTRL, C_RUN);
    tick_chk(16'd6, 1'b0, "R9 resumes");
  endtask

  task automatic t_load_override;
    wr(A_BUF, 16'd4);
    wr(A_CTRL, C_LOAD | C_RUN | C_AUTO);
    tick_chk(16'd4, 1'b0, "R3 load beats tick");
    tick_chk(16'd4, 1'b0, "R3 load held");
    wr(A_CTRL, C_RUN | C_AUTO);
    rd(A_CNT, 16'd4, "R3 load on last cycle");
    tick_chk(16'd3, 1'b0, "R3 counts after release");
  endtask

  task automatic t_zero_period;
    manual_load(16'd0, C_RUN | C_AUTO);
    tick_chk(16'd0, 1'b1, "R5 zero buffer expiry 1");
    tick_chk(16'd0, 1'b1, "R7 zero buffer expiry 2");
    idle(1);
    check("R7 no pulse without tick", W'(irq_pulse), '0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regmap;
    t_load_and_hold;
    t_one_shot;
    t_auto_reload;
    t_freeze;
    t_load_override;
    t_zero_period;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule